// File: doc/BRIEF.md
# Four-Bit ALU with Condition Flags

This block is the arithmetic and logic stage of a very small processor datapath. It is purely combinational: two 4-bit operands and a 4-bit operation code go in, and a 4-bit result comes out in the same cycle. A 4-bit condition vector also comes out, ready to be captured by a separate condition register.

Six operations are decoded: addition, subtraction, bitwise AND, bitwise OR, one's complement of operand A, and a copy of operand A. The sign and zero flags follow the result for every operation. The overflow and carry flags report arithmetic outcomes only. Codes outside the six defined ones yield a zero result and a zero-indicating flag vector.

Top module: `alu4_nzvc`

## Requirements
- R1: Code 0000 gives opnd_a + opnd_b modulo 16. The carry flag C is 1 exactly when the unsigned sum exceeds 15, which is bit 4 of the sum of the zero-extended 5-bit operands.
- R2: Code 0001 gives opnd_a - opnd_b modulo 16. C is 1 exactly when opnd_a < opnd_b as unsigned values (a borrow), which is bit 4 of the 5-bit zero-extended difference.
- R3: On code 0000 the overflow flag V is 1 exactly when both operands have the same sign bit and the result's sign bit differs from it.
- R4: On code 0001 V is 1 exactly when the operand sign bits differ and the result's sign bit differs from that of opnd_a.
- R5: Code 0010 gives the bitwise AND of the operands, and code 0011 gives the bitwise OR.
- R6: Code 0100 gives the bitwise inverse of opnd_a, and code 0101 gives opnd_a unchanged. opnd_b has no effect on either.
- R7: For every code, N equals bit 3 of the result, and Z is 1 exactly when the result is 0000.
- R8: V and C are 0 for codes 0010 through 0101.
- R9: Codes 0110 through 1111 give result 0000 and flags N=0, Z=1, V=0, C=0 (cc_flags = 0100).
- R10: cc_flags is packed with N in bit 3, Z in bit 2, V in bit 1 and C in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 4 | First operand |
| opnd_b | input | 4 | Second operand |
| op_code | input | 4 | Operation select |
| alu_result | output | 4 | Operation result |
| cc_flags | output | 4 | Condition vector {N, Z, V, C} |

## Verification
The embedded immediate assertions check four properties whenever the inputs change. Z must agree with a zero result. N must follow the result's sign bit. V and C must stay low outside the arithmetic codes. Overflow must match the sign-rule definition, which differs from the carry-chain form the datapath uses. The exact sums, differences, borrow outcomes and bitwise results for every operand pair can only be shown by the bench's exhaustive sweep of all sixteen codes against its own arithmetic model. The same holds for opnd_b having no effect on the complement and copy codes, and for the fixed output of the unused codes.

// File: rtl/alu4_pkg.sv
package alu4_pkg;
    localparam int DATA_W = 4;
    localparam int CODE_W = 4;

    // Flag bit positions inside the condition vector
    localparam int FLG_N = 3;
    localparam int FLG_Z = 2;
    localparam int FLG_V = 1;
    localparam int FLG_C = 0;

    typedef enum logic [CODE_W-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_INV  = 4'd4,
        OP_COPY = 4'd5
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND  = 2'd0,
        LG_OR   = 2'd1,
        LG_INV  = 2'd2,
        LG_COPY = 2'd3
    } logic_sel_e;
endpackage

// File: rtl/alu4_arith.sv
module alu4_arith #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         do_sub,
    output logic [W-1:0] sum,
    output logic         carry,
    output logic         ovf
);
    logic [W:0]   wide;
    logic [W-1:0] low;
    logic         into_msb;

    always_comb begin
        if (do_sub) begin
            wide = {1'b0, a} - {1'b0, b};
            low  = {1'b0, a[W-2:0]} - {1'b0, b[W-2:0]};
        end else begin
            wide = {1'b0, a} + {1'b0, b};
            low  = {1'b0, a[W-2:0]} + {1'b0, b[W-2:0]};
        end
        into_msb = low[W-1];
        sum      = wide[W-1:0];
        carry    = wide[W];
        // carry (or borrow) into the top bit differing from the one out of it
        ovf      = into_msb ^ wide[W];
    end
endmodule

// File: rtl/alu4_logic.sv
module alu4_logic
    import alu4_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic_sel_e   sel,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (sel)
            LG_AND:  y = a & b;
            LG_OR:   y = a | b;
            LG_INV:  y = ~a;
            LG_COPY: y = a;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/alu4_flags.sv
module alu4_flags
    import alu4_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] res,
    input  logic         arith_en,
    input  logic         ovf,
    input  logic         carry,
    output logic [3:0]   flags
);
    always_comb begin
        flags        = '0;
        flags[FLG_N] = res[W-1];
        flags[FLG_Z] = ~|res;
        flags[FLG_V] = arith_en & ovf;
        flags[FLG_C] = arith_en & carry;
    end
endmodule

// File: rtl/alu4_nzvc.sv
module alu4_nzvc
    import alu4_pkg::*;
(
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [CODE_W-1:0] op_code,
    output logic [DATA_W-1:0] alu_result,
    output logic [3:0]        cc_flags
);
    logic [DATA_W-1:0] ar_sum;
    logic [DATA_W-1:0] lg_y;
    logic              ar_carry;
    logic              ar_ovf;
    logic              is_arith;
    logic              is_logic;
    logic              is_sub;
    logic_sel_e        lg_sel;

    always_comb begin
        is_arith = 1'b0;
        is_logic = 1'b0;
        is_sub   = 1'b0;
        lg_sel   = LG_AND;
        case (op_code)
            OP_ADD:  is_arith = 1'b1;
            OP_SUB:  begin is_arith = 1'b1; is_sub = 1'b1; end
            OP_AND:  begin is_logic = 1'b1; lg_sel = LG_AND;  end
            OP_OR:   begin is_logic = 1'b1; lg_sel = LG_OR;   end
            OP_INV:  begin is_logic = 1'b1; lg_sel = LG_INV;  end
            OP_COPY: begin is_logic = 1'b1; lg_sel = LG_COPY; end
            default: ;
        endcase
    end

    alu4_arith #(.W(DATA_W)) u_arith (
        .a      (opnd_a),
        .b      (opnd_b),
        .do_sub (is_sub),
        .sum    (ar_sum),
        .carry  (ar_carry),
        .ovf    (ar_ovf)
    );

    alu4_logic #(.W(DATA_W)) u_logic (
        .a   (opnd_a),
        .b   (opnd_b),
        .sel (lg_sel),
        .y   (lg_y)
    );

    always_comb begin
        if (is_arith)      alu_result = ar_sum;
        else if (is_logic) alu_result = lg_y;
        else               alu_result = '0;
    end

    alu4_flags #(.W(DATA_W)) u_flags (
        .res      (alu_result),
        .arith_en (is_arith),
        .ovf      (ar_ovf),
        .carry    (ar_carry),
        .flags    (cc_flags)
    );

    always_comb begin
        assert_zero_flag_R7: assert (cc_flags[FLG_Z] == (alu_result == '0))
            else $error("Z flag disagrees with result");
        assert_sign_flag_R7: assert (cc_flags[FLG_N] == alu_result[DATA_W-1])
            else $error("N flag disagrees with result sign");
        if (op_code > OP_SUB) begin
            assert_no_arith_flags_R8: assert (cc_flags[FLG_V:FLG_C] == 2'b00)
                else $error("V/C set on non-arithmetic code");
        end
        if (op_code == OP_ADD) begin
            assert_add_overflow_R3: assert (cc_flags[FLG_V] ==
                ((opnd_a[DATA_W-1] == opnd_b[DATA_W-1]) &&
                 (alu_result[DATA_W-1] != opnd_a[DATA_W-1])))
                else $error("add overflow rule broken");
        end
        if (op_code == OP_SUB) begin
            assert_sub_overflow_R4: assert (cc_flags[FLG_V] ==
                ((opnd_a[DATA_W-1] != opnd_b[DATA_W-1]) &&
                 (alu_result[DATA_W-1] != opnd_a[DATA_W-1])))
                else $error("subtract overflow rule broken");
        end
    end
endmodule

// File: tb/alu4_nzvc_tb.sv
module alu4_nzvc_tb;
    logic       clk = 1'b0;
    logic [3:0] opnd_a = '0;
    logic [3:0] opnd_b = '0;
    logic [3:0] op_code = 4'd15;
    logic [3:0] alu_result;
    logic [3:0] cc_flags;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    alu4_nzvc u_dut (
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .op_code    (op_code),
        .alu_result (alu_result),
        .cc_flags   (cc_flags)
    );

    task automatic check4(input string req, input string what,
                          input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s op=%0d a=%0d b=%0d actual=%b expected=%b",
                     req, what, op_code, opnd_a, opnd_b, act, exp);
        end
    endtask

    initial begin
        // initial state: unused code, zero operands (R9)
        @(negedge clk);
        #1;
        check4("R9", "initial result", alu_result, 4'b0000);
        check4("R9", "initial flags", cc_flags, 4'b0100);

        for (int op = 0; op < 16; op++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    logic [3:0] er;
                    logic       ev, ec;
                    string      rq;
                    int         full;
                    @(negedge clk);
                    op_code = 4'(op);
                    opnd_a  = 4'(a);
                    opnd_b  = 4'(b);
                    #1;
                    ev = 1'b0;
                    ec = 1'b0;
                    case (op)
                        0: begin
                            full = a + b;
                            er = 4'(full);
                            ec = (full > 15);
                            ev = (opnd_a[3] == opnd_b[3]) && (er[3] != opnd_a[3]);
                            rq = "R1/R3";
                        end
                        1: begin
                            er = 4'(a - b);
                            ec = (a < b);
                            ev = (opnd_a[3] != opnd_b[3]) && (er[3] != opnd_a[3]);
                            rq = "R2/R4";
                        end
                        2: begin er = opnd_a & opnd_b; rq = "R5/R8"; end
                        3: begin er = opnd_a | opnd_b; rq = "R5/R8"; end
                        4: begin er = ~opnd_a;         rq = "R6/R8"; end
                        5: begin er = opnd_a;          rq = "R6/R8"; end
                        default: begin er = 4'b0000;   rq = "R9"; end
                    endcase
                    check4(rq, "result", alu_result, er);
                    // R7 and R10: {N, Z, V, C}
                    check4({rq, "/R7/R10"}, "flags", cc_flags,
                           {er[3], (er == 4'b0000), ev, ec});
                end
            end
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule